// File: doc/BRIEF.md
# CPU Hot-Plug Slot Event Controller

This block keeps the hot-plug bookkeeping for a fixed set of CPU slots and presents it to system software through a small register window of 12 bytes. Software first points a slot selector at one slot. It then reads that slot's flag byte, or writes the flag byte to acknowledge events, eject the CPU or hand removal over to firmware. A command byte decides what the 32-bit data port means. The data port can show the result of a circular search for the next slot with pending work, show the slot's 64-bit architecture identifier, or accept OST event and status codes.

The platform side reports three things: a CPU was plugged, a CPU removal was requested, and a CPU removal has completed. Each plug or removal request sets a per-slot event and produces a one-cycle interrupt pulse. An accepted eject leaves the block as a one-cycle pulse that carries the slot number. An OST status write leaves as a one-cycle report that carries the slot, the stored event code and the status. Architecture identifiers are computed as `ID_BASE + slot * ID_STRIDE`.

Top module: `cpuhp_top`

## Requirements
- R1: Register offsets, all byte addresses on `busAddr`:
  - offset 0 takes a 32-bit selector write, and a read there returns the upper data word;
  - offset 4 is the flag byte (`busWdata[7:0]` on write);
  - offset 5 is the command byte (`busWdata[7:0]`);
  - offset 8 is the 32-bit data port;
  - a read at any other offset, offset 5 included, returns 0.
- R2: A flag read returns bit0 = present, bit1 = insert event, bit2 = remove event and bit4 = firmware-remove pending, with all other bits 0. After reset only slot 0 is present and every event and firmware-remove flag is clear.
- R3: A flag write acts only on its highest-priority set bit. Bit1 clears the insert event. Otherwise bit2 clears the remove event. Otherwise bit3 requests an eject. Otherwise bit4 sets firmware-remove.
- R4: Eject and firmware-remove requests are ignored when the selected slot is not present or is slot 0. An accepted eject clears present and firmware-remove. In the cycle after the write it pulses `ejectVld` for one cycle, with `ejectSlot` set to the slot.
- R5: Command codes are 0 = next slot with event, 1 = OST event, 2 = OST status and 3 = CPU ID. A command byte of 4 or more is ignored and the previous command stays in force.
- R6: Writing command 0 searches the slots starting at the selector, counting upward and wrapping from the last slot to slot 0. It loads the first slot with insert, remove or firmware-remove set into the selector. If no slot has one of these set, the selector is unchanged.
- R7: Under command 0 the data port reads the selector and offset 0 reads 0. Under command 3 the data port reads bits 31:0 of the identifier and offset 0 reads bits 63:32. Under command 1 or 2 both read 0.
- R8: Under command 1, a data write stores the selected slot's OST event. Under command 2, a data write pulses `ostVld` for one cycle in the next cycle, with the slot, that slot's stored event and the written status.
- R9: While the selector is not below `NUM_SLOTS`, every read returns 0 and writes to any offset other than 0 have no effect.
- R10: A plug sets present and the insert event. A removal request sets the remove event. Either one pulses `eventIrq` in the next cycle. A completed removal clears present. Slot numbers not below `NUM_SLOTS` are ignored.
- R11: When a platform event and a software write reach the same slot in the same cycle, the set wins. A plug keeps insert and present set against a clear or an eject. A removal request keeps the remove event set against a clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWe | input | 1 | Register write strobe |
| busAddr | input | 4 | Register byte offset |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for `busAddr` (combinational) |
| plugVld | input | 1 | CPU plugged |
| plugSlot | input | SLOT_W | Slot of the plugged CPU |
| unplugReqVld | input | 1 | Removal requested |
| unplugReqSlot | input | SLOT_W | Slot of the removal request |
| unplugDoneVld | input | 1 | Removal completed |
| unplugDoneSlot | input | SLOT_W | Slot of the completed removal |
| eventIrq | output | 1 | One-cycle event interrupt |
| ejectVld | output | 1 | One-cycle eject pulse |
| ejectSlot | output | SLOT_W | Slot being ejected |
| ostVld | output | 1 | One-cycle OST status report |
| ostSlot | output | SLOT_W | Slot of the OST report |
| ostEvent | output | 32 | Stored OST event of that slot |
| ostStatus | output | 32 | Written OST status |

## Verification
A platform event and a software flag write can land on the same slot in the same cycle. The cases are a plug against an insert-clear, a plug against an accepted eject, and a removal request against a remove-clear. The bench drives each pair in one cycle. On every clock it compares the flag byte read back, and the interrupt and eject pulses, with a reference model in which the set is applied after the clear. A command-0 search issued in a cycle where a new event arrives is judged the same way: the search must see only the flags held before that cycle.

// File: rtl/cpuhp_pkg.sv
package cpuhp_pkg;
  localparam logic [3:0] OFF_SEL   = 4'd0;
  localparam logic [3:0] OFF_FLAGS = 4'd4;
  localparam logic [3:0] OFF_CMD   = 4'd5;
  localparam logic [3:0] OFF_DATA  = 4'd8;

  typedef enum logic [1:0] {
    CMD_NEXT   = 2'd0,
    CMD_OST_EV = 2'd1,
    CMD_OST_ST = 2'd2,
    CMD_CPU_ID = 2'd3
  } cmd_e;

  // strobes from register control to slot datapath
  typedef struct packed {
    logic        clrIns;
    logic        clrRmv;
    logic        eject;
    logic        fwSet;
    logic        ostEvWr;
    logic        ostStWr;
    logic [7:0]  slot;
    logic [31:0] data;
  } strobes_t;
endpackage

// File: rtl/cpuhp_ctrl.sv
module cpuhp_ctrl
  import cpuhp_pkg::*;
#(
  parameter int          NUM_SLOTS = 8,
  parameter logic [63:0] ID_BASE   = 64'h0000_0A00_0000_0010,
  parameter logic [63:0] ID_STRIDE = 64'h0000_0001_0000_0001,
  localparam int         SLOT_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 busWe,
  input  logic [3:0]           busAddr,
  input  logic [31:0]          busWdata,
  output logic [31:0]          busRdata,
  input  logic [NUM_SLOTS-1:0] presVec,
  input  logic [NUM_SLOTS-1:0] insVec,
  input  logic [NUM_SLOTS-1:0] rmvVec,
  input  logic [NUM_SLOTS-1:0] fwVec,
  output strobes_t             strb
);
  localparam logic [SLOT_W:0] N_EXT = (SLOT_W+1)'(NUM_SLOTS);

  logic [31:0]          selQ;
  cmd_e                 cmdQ;
  logic                 selOk;
  logic [SLOT_W-1:0]    selIdx;
  logic [NUM_SLOTS-1:0] pendVec;
  logic                 found;
  logic [SLOT_W-1:0]    foundIdx;
  logic [63:0]          archId;

  assign selOk   = selQ < 32'(NUM_SLOTS);
  assign selIdx  = selQ[SLOT_W-1:0];
  assign pendVec = insVec | rmvVec | fwVec;
  assign archId  = ID_BASE + ID_STRIDE * 64'(selIdx);

  // circular search starting at the selector
  always_comb begin
    logic [SLOT_W:0] cand;
    found    = 1'b0;
    foundIdx = '0;
    for (int k = 0; k < NUM_SLOTS; k++) begin
      cand = {1'b0, selIdx} + (SLOT_W+1)'(k);
      if (cand >= N_EXT) cand = cand - N_EXT;
      if (!found && pendVec[cand[SLOT_W-1:0]]) begin
        found    = 1'b1;
        foundIdx = cand[SLOT_W-1:0];
      end
    end
  end

  // strobe decode, flag bits by priority
  always_comb begin
    strb      = '0;
    strb.slot = 8'(selIdx);
    strb.data = busWdata;
    if (busWe && selOk) begin
      if (busAddr == OFF_FLAGS) begin
        if (busWdata[1])      strb.clrIns = 1'b1;
        else if (busWdata[2]) strb.clrRmv = 1'b1;
        else if (busWdata[3]) strb.eject  = 1'b1;
        else if (busWdata[4]) strb.fwSet  = 1'b1;
      end else if (busAddr == OFF_DATA) begin
        strb.ostEvWr = (cmdQ == CMD_OST_EV);
        strb.ostStWr = (cmdQ == CMD_OST_ST);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selQ <= '0;
      cmdQ <= CMD_NEXT;
    end else if (busWe) begin
      if (busAddr == OFF_SEL) begin
        selQ <= busWdata;
      end else if (selOk && busAddr == OFF_CMD && busWdata[7:0] < 8'd4) begin
        cmdQ <= cmd_e'(busWdata[1:0]);
        if (busWdata[1:0] == 2'd0 && found) selQ <= 32'(foundIdx);
      end
    end
  end

  always_comb begin
    busRdata = '0;
    if (selOk) begin
      case (busAddr)
        OFF_SEL:   if (cmdQ == CMD_CPU_ID) busRdata = archId[63:32];
        OFF_FLAGS: busRdata = {27'd0, fwVec[selIdx], 1'b0, rmvVec[selIdx],
                               insVec[selIdx], presVec[selIdx]};
        OFF_DATA: begin
          if (cmdQ == CMD_NEXT)        busRdata = selQ;
          else if (cmdQ == CMD_CPU_ID) busRdata = archId[31:0];
        end
        default: busRdata = '0;
      endcase
    end
  end

  // R5
  cmd_change_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(cmdQ) |-> $past(busWe && busAddr == OFF_CMD && busWdata[7:0] < 8'd4));

  // R6
  scan_lands_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == OFF_CMD && busWdata[7:0] == 8'd0 && selOk && (|pendVec))
      |=> pendVec[selIdx]);
endmodule

// File: rtl/cpuhp_slots.sv
module cpuhp_slots
  import cpuhp_pkg::*;
#(
  parameter int  NUM_SLOTS = 8,
  localparam int SLOT_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobes_t             strb,
  input  logic                 plugVld,
  input  logic [SLOT_W-1:0]    plugSlot,
  input  logic                 unplugReqVld,
  input  logic [SLOT_W-1:0]    unplugReqSlot,
  input  logic                 unplugDoneVld,
  input  logic [SLOT_W-1:0]    unplugDoneSlot,
  output logic [NUM_SLOTS-1:0] presVec,
  output logic [NUM_SLOTS-1:0] insVec,
  output logic [NUM_SLOTS-1:0] rmvVec,
  output logic [NUM_SLOTS-1:0] fwVec,
  output logic                 eventIrq,
  output logic                 ejectVld,
  output logic [SLOT_W-1:0]    ejectSlot,
  output logic                 ostVld,
  output logic [SLOT_W-1:0]    ostSlot,
  output logic [31:0]          ostEvent,
  output logic [31:0]          ostStatus
);
  logic [SLOT_W-1:0] tgt;
  logic              tgtLive;
  logic              ejAcc;
  logic              fwAcc;
  logic              plugOk;
  logic              reqOk;
  logic [31:0]       ostEvQ [NUM_SLOTS];

  assign tgt     = strb.slot[SLOT_W-1:0];
  assign tgtLive = presVec[tgt] && (tgt != '0);
  assign ejAcc   = strb.eject && tgtLive;
  assign fwAcc   = strb.fwSet && tgtLive;
  assign plugOk  = plugVld && (32'(plugSlot) < 32'(NUM_SLOTS));
  assign reqOk   = unplugReqVld && (32'(unplugReqSlot) < 32'(NUM_SLOTS));

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    logic onMe, hitPlug, hitReq, hitDone;
    assign onMe    = (tgt == SLOT_W'(i));
    assign hitPlug = plugVld && plugSlot == SLOT_W'(i);
    assign hitReq  = unplugReqVld && unplugReqSlot == SLOT_W'(i);
    assign hitDone = unplugDoneVld && unplugDoneSlot == SLOT_W'(i);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        presVec[i] <= (i == 0);
        insVec[i]  <= 1'b0;
        rmvVec[i]  <= 1'b0;
        fwVec[i]   <= 1'b0;
        ostEvQ[i]  <= '0;
      end else begin
        if (hitPlug)                        presVec[i] <= 1'b1;
        else if (hitDone || (ejAcc && onMe)) presVec[i] <= 1'b0;
        if (hitPlug)                        insVec[i] <= 1'b1;
        else if (strb.clrIns && onMe)       insVec[i] <= 1'b0;
        if (hitReq)                         rmvVec[i] <= 1'b1;
        else if (strb.clrRmv && onMe)       rmvVec[i] <= 1'b0;
        if (fwAcc && onMe)                  fwVec[i] <= 1'b1;
        else if (ejAcc && onMe)             fwVec[i] <= 1'b0;
        if (strb.ostEvWr && onMe)           ostEvQ[i] <= strb.data;
      end
    end

    // R10
    ins_source_chk: assert property (@(posedge clk) disable iff (!rstN)
      $rose(insVec[i]) |-> $past(plugVld && plugSlot == SLOT_W'(i)));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      eventIrq  <= 1'b0;
      ejectVld  <= 1'b0;
      ejectSlot <= '0;
      ostVld    <= 1'b0;
      ostSlot   <= '0;
      ostEvent  <= '0;
      ostStatus <= '0;
    end else begin
      eventIrq <= plugOk || reqOk;
      ejectVld <= ejAcc;
      ostVld   <= strb.ostStWr;
      if (ejAcc) ejectSlot <= tgt;
      if (strb.ostStWr) begin
        ostSlot   <= tgt;
        ostEvent  <= ostEvQ[tgt];
        ostStatus <= strb.data;
      end
    end
  end

  // R4
  boot_guard_chk: assert property (@(posedge clk) disable iff (!rstN)
    ejectVld |-> ejectSlot != '0);

  // R4
  boot_fw_chk: assert property (@(posedge clk) disable iff (!rstN)
    !fwVec[0]);

  // R10
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    eventIrq |-> $past(plugVld || unplugReqVld));
endmodule

// File: rtl/cpuhp_top.sv
module cpuhp_top
  import cpuhp_pkg::*;
#(
  parameter int          NUM_SLOTS = 8,
  parameter logic [63:0] ID_BASE   = 64'h0000_0A00_0000_0010,
  parameter logic [63:0] ID_STRIDE = 64'h0000_0001_0000_0001,
  localparam int         SLOT_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic [3:0]        busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  input  logic              plugVld,
  input  logic [SLOT_W-1:0] plugSlot,
  input  logic              unplugReqVld,
  input  logic [SLOT_W-1:0] unplugReqSlot,
  input  logic              unplugDoneVld,
  input  logic [SLOT_W-1:0] unplugDoneSlot,
  output logic              eventIrq,
  output logic              ejectVld,
  output logic [SLOT_W-1:0] ejectSlot,
  output logic              ostVld,
  output logic [SLOT_W-1:0] ostSlot,
  output logic [31:0]       ostEvent,
  output logic [31:0]       ostStatus
);
  strobes_t             strb;
  logic [NUM_SLOTS-1:0] presVec, insVec, rmvVec, fwVec;

  cpuhp_ctrl #(
    .NUM_SLOTS(NUM_SLOTS), .ID_BASE(ID_BASE), .ID_STRIDE(ID_STRIDE)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .presVec(presVec),
    .insVec(insVec), .rmvVec(rmvVec), .fwVec(fwVec), .strb(strb)
  );

  cpuhp_slots #(.NUM_SLOTS(NUM_SLOTS)) u_slots (
    .clk(clk), .rstN(rstN), .strb(strb),
    .plugVld(plugVld), .plugSlot(plugSlot),
    .unplugReqVld(unplugReqVld), .unplugReqSlot(unplugReqSlot),
    .unplugDoneVld(unplugDoneVld), .unplugDoneSlot(unplugDoneSlot),
    .presVec(presVec), .insVec(insVec), .rmvVec(rmvVec), .fwVec(fwVec),
    .eventIrq(eventIrq), .ejectVld(ejectVld), .ejectSlot(ejectSlot),
    .ostVld(ostVld), .ostSlot(ostSlot), .ostEvent(ostEvent),
    .ostStatus(ostStatus)
  );
endmodule

// File: tb/cpuhp_top_bench.sv
module cpuhp_top_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 6;
  localparam int SW = 3;
  localparam logic [63:0] IDB = 64'h0000_0A00_0000_0010;
  localparam logic [63:0] IDS = 64'h0000_0001_0000_0001;

  logic clk = 0, rstN = 0;
  logic busWe = 0;
  logic [3:0] busAddr = 0;
  logic [31:0] busWdata = 0, busRdata;
  logic plugVld = 0, unplugReqVld = 0, unplugDoneVld = 0;
  logic [SW-1:0] plugSlot = 0, unplugReqSlot = 0, unplugDoneSlot = 0;
  logic eventIrq, ejectVld, ostVld;
  logic [SW-1:0] ejectSlot, ostSlot;
  logic [31:0] ostEvent, ostStatus;

  int total = 0, bad = 0;
  string phase = "R2";

  always #(CLK_PERIOD/2) clk = ~clk;

  cpuhp_top #(.NUM_SLOTS(NS), .ID_BASE(IDB), .ID_STRIDE(IDS)) u_cpuhp_top (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata),
    .plugVld(plugVld), .plugSlot(plugSlot),
    .unplugReqVld(unplugReqVld), .unplugReqSlot(unplugReqSlot),
    .unplugDoneVld(unplugDoneVld), .unplugDoneSlot(unplugDoneSlot),
    .eventIrq(eventIrq), .ejectVld(ejectVld), .ejectSlot(ejectSlot),
    .ostVld(ostVld), .ostSlot(ostSlot), .ostEvent(ostEvent),
    .ostStatus(ostStatus)
  );

  // reference model
  bit mPres[NS], mIns[NS], mRmv[NS], mFw[NS];
  logic [31:0] mOstEv[NS];
  logic [31:0] mSel;
  int mCmd;
  bit mIrq, mEjV, mOstV;
  int mEjS, mOstS;
  logic [31:0] mOstE, mOstSt;

  task automatic modelReset();
    for (int i = 0; i < NS; i++) begin
      mPres[i] = (i == 0); mIns[i] = 0; mRmv[i] = 0; mFw[i] = 0; mOstEv[i] = 0;
    end
    mSel = 0; mCmd = 0; mIrq = 0; mEjV = 0; mOstV = 0;
  endtask

  always @(posedge clk or negedge rstN) begin
    if (!rstN) modelReset();
    else begin
      int s;
      s = mSel;
      mIrq = (plugVld && plugSlot < NS) || (unplugReqVld && unplugReqSlot < NS);
      mEjV = 0; mOstV = 0;
      if (busWe) begin
        if (busAddr == 0) mSel = busWdata;
        else if (mSel < NS) begin
          if (busAddr == 4) begin
            if (busWdata[1]) mIns[s] = 0;
            else if (busWdata[2]) mRmv[s] = 0;
            else if (busWdata[3]) begin
              if (mPres[s] && s != 0) begin
                mPres[s] = 0; mFw[s] = 0; mEjV = 1; mEjS = s;
              end
            end else if (busWdata[4]) begin
              if (mPres[s] && s != 0) mFw[s] = 1;
            end
          end else if (busAddr == 5) begin
            if (busWdata[7:0] < 4) begin
              mCmd = busWdata[7:0];
              if (mCmd == 0)
                for (int k = 0; k < NS; k++) begin
                  int j;
                  j = (s + k) % NS;
                  if (mIns[j] || mRmv[j] || mFw[j]) begin mSel = j; break; end
                end
            end
          end else if (busAddr == 8) begin
            if (mCmd == 1) mOstEv[s] = busWdata;
            else if (mCmd == 2) begin
              mOstV = 1; mOstS = s; mOstE = mOstEv[s]; mOstSt = busWdata;
            end
          end
        end
      end
      if (unplugDoneVld && unplugDoneSlot < NS) mPres[unplugDoneSlot] = 0;
      if (plugVld && plugSlot < NS) begin mPres[plugSlot] = 1; mIns[plugSlot] = 1; end
      if (unplugReqVld && unplugReqSlot < NS) mRmv[unplugReqSlot] = 1;
    end
  end

  function automatic logic [31:0] expRd(logic [3:0] a);
    logic [63:0] id;
    int s;
    if (mSel >= NS) return 0;
    s = mSel;
    id = IDB + IDS * 64'(s);
    case (a)
      4'd0: return (mCmd == 3) ? id[63:32] : 0;
      4'd4: return {27'd0, mFw[s], 1'b0, mRmv[s], mIns[s], mPres[s]};
      4'd8: return (mCmd == 0) ? mSel : (mCmd == 3) ? id[31:0] : 0;
      default: return 0;
    endcase
  endfunction

  task automatic chk(string req, string what, logic [63:0] got, logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s got=%0h exp=%0h t=%0t", req, what, got, exp, $time);
    end
  endtask

  // compare every cycle, after the edge
  always @(posedge clk) begin
    #2;
    if (rstN) begin
      chk((mSel >= NS) ? "R9" : phase, "rdata", busRdata, expRd(busAddr));
      chk("R10", "eventIrq", eventIrq, mIrq);
      chk("R4", "ejectVld", ejectVld, mEjV);
      if (mEjV) chk("R4", "ejectSlot", ejectSlot, mEjS);
      chk("R8", "ostVld", ostVld, mOstV);
      if (mOstV) begin
        chk("R8", "ostSlot", ostSlot, mOstS);
        chk("R8", "ostEvent", ostEvent, mOstE);
        chk("R8", "ostStatus", ostStatus, mOstSt);
      end
    end
  end

  task automatic cyc(bit we, logic [3:0] a, logic [31:0] d,
                     bit pv = 0, int ps = 0, bit rv = 0, int rs = 0,
                     bit dv = 0, int ds = 0);
    @(negedge clk);
    busWe = we; busAddr = a; busWdata = d;
    plugVld = pv; plugSlot = SW'(ps);
    unplugReqVld = rv; unplugReqSlot = SW'(rs);
    unplugDoneVld = dv; unplugDoneSlot = SW'(ds);
    @(negedge clk);
    busWe = 0; plugVld = 0; unplugReqVld = 0; unplugDoneVld = 0;
  endtask

  task automatic rd(logic [3:0] a);
    cyc(0, a, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    // R2 reset state
    phase = "R2";
    rd(4);
    @(posedge clk); #3;
    chk("R2", "slot0 flags", busRdata, 32'h1);
    cyc(1, 0, 3); rd(4);
    @(posedge clk); #3;
    chk("R2", "slot3 flags", busRdata, 32'h0);
    // R10 platform events
    phase = "R10";
    cyc(0, 4, 0, 1, 2);
    cyc(0, 4, 0, 0, 0, 1, 4);
    cyc(0, 4, 0, 1, 7);            // out of range slot
    cyc(1, 0, 2); rd(4);
    cyc(1, 0, 4); rd(4);
    // R1 offsets
    phase = "R1";
    rd(0); rd(5); rd(12); rd(8);
    // R7 data port
    phase = "R7";
    cyc(1, 5, 3); rd(8); rd(0);
    cyc(1, 5, 0); rd(8); rd(0);
    // R5 illegal command
    phase = "R5";
    cyc(1, 5, 3); cyc(1, 5, 9); rd(8); rd(0);
    cyc(1, 5, 8'h80); rd(8);
    // R6 scan
    phase = "R6";
    cyc(1, 0, 3); cyc(1, 5, 0); rd(8);       // pending 2,4 -> 4
    cyc(1, 0, 5); cyc(1, 5, 0); rd(8);       // wrap -> 2
    cyc(1, 4, 2); cyc(1, 0, 4); cyc(1, 4, 4); // clear all events
    cyc(1, 0, 1); cyc(1, 5, 0); rd(8);       // none -> unchanged
    // R8 OST
    phase = "R8";
    cyc(1, 0, 2); cyc(1, 5, 1); cyc(1, 8, 32'h55);
    cyc(1, 5, 2); cyc(1, 8, 32'h77); rd(8);
    // R3 priority
    phase = "R3";
    cyc(0, 4, 0, 1, 3, 1, 3);
    cyc(1, 0, 3);
    cyc(1, 4, 32'h1E); rd(4);   // clears insert only
    cyc(1, 4, 32'h1C); rd(4);   // clears remove only
    cyc(1, 4, 32'h10); rd(4);   // fw set
    cyc(1, 4, 32'h18); rd(4);   // eject wins over fw
    // R4 guards
    phase = "R4";
    cyc(1, 0, 0); cyc(1, 4, 8); cyc(1, 4, 16); rd(4);
    cyc(1, 0, 3); cyc(1, 4, 8); cyc(1, 4, 16); rd(4);
    cyc(0, 4, 0, 1, 5); cyc(1, 0, 5); cyc(1, 4, 16); cyc(1, 4, 8); rd(4);
    // R9 out of range selector
    phase = "R9";
    cyc(1, 5, 3);
    cyc(1, 0, 9); rd(0); rd(4); rd(8);
    cyc(1, 5, 0); cyc(1, 4, 2);
    cyc(1, 0, 1); rd(8);        // command must still be 3
    // R11 same-cycle collisions
    phase = "R11";
    cyc(0, 4, 0, 1, 1);
    cyc(1, 0, 1);
    cyc(1, 4, 2, 1, 1); rd(4);            // plug vs clear insert
    cyc(1, 4, 8, 1, 1); rd(4);            // plug vs eject
    cyc(1, 4, 4, 0, 0, 1, 1); rd(4);      // request vs clear remove
    cyc(0, 4, 0, 1, 1, 0, 0, 1, 1); rd(4);// plug vs done
    cyc(1, 0, 3);
    cyc(1, 5, 0, 1, 4); rd(8);            // scan ignores same-cycle plug
    cyc(0, 4, 0, 0, 0, 0, 0, 1, 1); rd(4);
    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule